// File: doc/BRIEF.md
# BCD Hundredths Watchdog Timer

This block is a software watchdog that software arms by writing a timeout, in packed decimal, into two byte registers on a small register bus. One register holds the fractional part of the timeout (tenths in the high nibble, hundredths in the low nibble). The other holds whole seconds (tens in the high nibble, units in the low nibble). Together they give any timeout from 0.01 s up to 99.99 s. An external 100 Hz tick input, one clock wide, is produced by a prescaler elsewhere. Each tick moves a four-digit decimal down-counter one step, with borrow rippling between digits.

Software restarts the timer by writing either timeout register, which reloads the counter from both registers. When the count runs out, the block sets a sticky watchdog flag and stops until it is reloaded. A steering bit in the control register picks what happens next. With steering clear, a summary flag is set and the interrupt line rises. With steering set, a reset output pulses for a fixed number of clock cycles. Reading the status register returns the flags and clears them. A loaded value of zero leaves the timer disarmed.

Top module: `bcd_watchdog`

## Requirements
- R1: After reset, all four registers read 0x00, and `irq` and `wd_rst` are low.
- R2: Offsets 0x0C (fraction) and 0x0D (seconds) read back the last byte written. The control register at offset 0x0F keeps only bit 1 (enable) and bit 0 (steering); its other bits read 0.
- R3: With enable set, a loaded value of seconds S and fraction F (both BCD) expires on exactly tick number 100*S + F after the reload, never earlier. Borrow crosses from the fraction digits into the seconds digits.
- R4: While enable (control bit 1) is clear, ticks leave the count unchanged.
- R5: On expiry with steering (control bit 0) clear, status bit 1 (watchdog flag) and status bit 0 (summary flag) are set, `irq` goes high, and `wd_rst` stays low.
- R6: On expiry with steering set, status bit 1 alone is set, `wd_rst` is high for exactly 16 consecutive clock cycles, and `irq` stays low.
- R7: The status flags at offset 0x0E stay set until that register is read. The read returns the flags, clears them, and drops `irq`.
- R8: A write to either timeout register restarts the count from the full value held in both registers.
- R9: A loaded value of 0x0000 never expires.
- R10: After expiry the timer stays stopped, and later ticks raise no new flag until a timeout register is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_100hz | input | 1 | One-cycle pulse at 100 Hz from the prescaler |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (5) | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered one cycle after `rd_en` |
| irq | output | 1 | Interrupt request, high while the summary flag is set |
| wd_rst | output | 1 | Reset pulse on expiry when steering is set |

## Verification
The checker assumes that `tick_100hz` is a clean one-cycle pulse. It also assumes that software does not re-arm and expire the timer a second time while a reset pulse is still running, because that would stretch the pulse beyond its fixed length. The bench keeps within both assumptions. It spaces ticks at least one idle cycle apart, uses only short timeouts, and always reads status and waits out the full `wd_rst` pulse before reloading. Every expiry is then checked one tick before and exactly at the tick predicted from the BCD value.

// File: rtl/wdt_pkg.sv
// Shared register offsets and control type for the BCD watchdog.
// Assumes byte-wide registers and a decoded offset bus.
package wdt_pkg;
    localparam int OFS_FRAC = 12;  // tenths | hundredths
    localparam int OFS_SECS = 13;  // tens | units of seconds
    localparam int OFS_STAT = 14;  // bit1 watchdog flag, bit0 summary flag
    localparam int OFS_CTRL = 15;  // bit1 enable, bit0 steering

    typedef struct packed {
        logic en;     // counting permitted
        logic steer;  // 1: reset pulse, 0: interrupt
    } wdt_ctrl_t;
endpackage

// File: rtl/bcd_down_counter.sv
// Multi-digit packed-BCD down counter with parallel load.
// Assumes load values hold valid BCD digits; load overrides decrement.
module bcd_down_counter #(
    parameter int DIGITS = 4,
    localparam int CNT_W = 4 * DIGITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             at_one
);
    logic [DIGITS:0]    borrow;
    logic [CNT_W-1:0]   next_cnt;

    assign borrow[0] = dec;

    // Per-digit decrement with borrow ripple toward the top digit
    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        logic [3:0] cur;
        assign cur = count[4*d +: 4];
        always_comb begin
            if (borrow[d]) begin
                next_cnt[4*d +: 4] = (cur == 4'd0) ? 4'd9 : cur - 4'd1;
                borrow[d+1]        = (cur == 4'd0);
            end else begin
                next_cnt[4*d +: 4] = cur;
                borrow[d+1]        = 1'b0;
            end
        end
    end

    // Count register: load takes priority over decrement
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (dec)
            count <= next_cnt;
    end

    // Final-step detection used by the expiry logic
    assign at_one = (count == CNT_W'(1));
endmodule

// File: rtl/wdt_regs.sv
// Byte register file: timeout bytes, control bits, status read path.
// Assumes wr_en and rd_en are never asserted in the same cycle.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wd_flag,
    input  logic              irq_flag,
    output logic [7:0]        frac_q,
    output logic [7:0]        secs_q,
    output wdt_ctrl_t         ctrl_q,
    output logic              reload,
    output logic              status_rd,
    output logic [7:0]        rdata
);
    logic hit_frac, hit_secs, hit_stat, hit_ctrl;

    // Offset decode
    assign hit_frac = (addr == ADDR_W'(OFS_FRAC));
    assign hit_secs = (addr == ADDR_W'(OFS_SECS));
    assign hit_stat = (addr == ADDR_W'(OFS_STAT));
    assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));

    assign status_rd = rd_en && hit_stat;

    // Writable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frac_q <= '0;
            secs_q <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (hit_frac) frac_q <= wdata;
            if (hit_secs) secs_q <= wdata;
            if (hit_ctrl) ctrl_q <= wdt_ctrl_t'(wdata[1:0]);
        end
    end

    // Reload strobe one cycle after a timeout write, once bytes are settled
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload <= 1'b0;
        else
            reload <= wr_en && (hit_frac || hit_secs);
    end

    // Registered read mux
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en) begin
            if (hit_frac)      rdata <= frac_q;
            else if (hit_secs) rdata <= secs_q;
            else if (hit_stat) rdata <= {6'b0, wd_flag, irq_flag};
            else if (hit_ctrl) rdata <= {6'b0, ctrl_q};
            else               rdata <= '0;
        end
    end
endmodule

// File: rtl/wdt_status.sv
// Sticky expiry flags with read-to-clear; a new expiry wins over a clear.
// Assumes expire is a single-cycle strobe.
module wdt_status (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic steer,
    input  logic clr,
    output logic wd_flag,
    output logic irq_flag
);
    // Flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_flag  <= 1'b0;
            irq_flag <= 1'b0;
        end else begin
            wd_flag  <= expire | (wd_flag & ~clr);
            irq_flag <= (expire & ~steer) | (irq_flag & ~clr);
        end
    end
endmodule

// File: rtl/wdt_rst_pulse.sv
// Fixed-length pulse stretcher for the watchdog reset output.
// Assumes CYCLES >= 1; a new start reloads the full length.
module wdt_rst_pulse #(
    parameter int CYCLES = 16,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse
);
    logic [CW-1:0] remain;

    // Remaining-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (start)
            remain <= CW'(CYCLES);
        else if (remain != '0)
            remain <= remain - CW'(1);
    end

    assign pulse = (remain != '0);
endmodule

// File: rtl/bcd_watchdog.sv
// Top of the BCD hundredths watchdog: register file, decimal counter,
// sticky flags and reset stretcher. Assumes tick_100hz is a 1-cycle pulse.
module bcd_watchdog
    import wdt_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_100hz,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              irq,
    output logic              wd_rst
);
    localparam int DIGITS = 4;
    localparam int CNT_W  = 4 * DIGITS;

    logic [7:0]       frac_q, secs_q;
    wdt_ctrl_t        ctrl_q;
    logic             reload, status_rd;
    logic             wd_flag, irq_flag;
    logic [CNT_W-1:0] load_val, count;
    logic             at_one, armed, step, expire;

    wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .wd_flag(wd_flag), .irq_flag(irq_flag),
        .frac_q(frac_q), .secs_q(secs_q), .ctrl_q(ctrl_q),
        .reload(reload), .status_rd(status_rd), .rdata(rdata)
    );

    assign load_val = {secs_q, frac_q};

    // A counting step happens on a tick while armed and enabled
    assign step   = tick_100hz && ctrl_q.en && armed && !reload;
    assign expire = step && at_one;

    bcd_down_counter #(.DIGITS(DIGITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(reload), .load_val(load_val),
        .dec(step), .count(count), .at_one(at_one)
    );

    // Armed state: set by a nonzero reload, dropped on expiry
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (reload)
            armed <= (load_val != '0);
        else if (expire)
            armed <= 1'b0;
    end

    wdt_status u_stat (
        .clk(clk), .rst_n(rst_n), .expire(expire), .steer(ctrl_q.steer),
        .clr(status_rd), .wd_flag(wd_flag), .irq_flag(irq_flag)
    );

    wdt_rst_pulse #(.CYCLES(RST_CYCLES)) u_pulse (
        .clk(clk), .rst_n(rst_n), .start(expire && ctrl_q.steer),
        .pulse(wd_rst)
    );

    assign irq = irq_flag;
endmodule

// File: rtl/bcd_watchdog_chk.sv
// Temporal checks on the watchdog, bound onto the top module.
// Assumes no re-expiry while a reset pulse is still running.
module bcd_watchdog_chk #(
    parameter int RST_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic tick_100hz,
    input logic status_rd,
    input logic wd_flag,
    input logic irq,
    input logic wd_rst
);
    logic [7:0] run_len;

    // Length of the current high run of wd_rst
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= '0;
        else if (wd_rst)
            run_len <= run_len + 8'd1;
        else
            run_len <= '0;
    end

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!irq && !wd_rst));

    // R3
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag) |-> $past(tick_100hz));

    // R5
    irq_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wd_flag);

    // R6
    rst_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst |-> (run_len < 8'(RST_CYCLES)));

    // R6
    rst_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst) |-> (run_len == 8'(RST_CYCLES)));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_flag) |-> $past(status_rd));
endmodule

bind bcd_watchdog bcd_watchdog_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz),
    .status_rd(status_rd), .wd_flag(wd_flag), .irq(irq), .wd_rst(wd_rst)
);

// File: tb/bcd_watchdog_tb.sv
`timescale 1ns/1ps
module bcd_watchdog_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_100hz = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, wd_rst;

    int total = 0;
    int bad = 0;
    logic rd_d = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    bcd_watchdog u_dut (
        .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .wd_rst(wd_rst)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) rd_d <= rd_en;

    // Monitor: pops expected read data one cycle after each read strobe
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (rdata !== e) begin
                bad++;
                $display("FAIL %s read act=%02h exp=%02h", t, rdata, e);
            end
        end
    end

    task automatic check(input logic act, input logic exp, input string t);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b", t, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        idle(1);
    endtask

    // Driver: pushes the expected byte, then issues the read
    task automatic rd(input logic [4:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        idle(1);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_100hz = 1'b1;
            @(negedge clk); tick_100hz = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check(irq, 1'b0, "R1 irq");
        check(wd_rst, 1'b0, "R1 wd_rst");
        rd(5'h0C, 8'h00, "R1 frac");
        rd(5'h0D, 8'h00, "R1 secs");
        rd(5'h0E, 8'h00, "R1 status");
        rd(5'h0F, 8'h00, "R1 ctrl");

        // R2 control keeps two bits, timeout bytes read back
        wr(5'h0F, 8'hFF);
        rd(5'h0F, 8'h03, "R2 ctrl mask");
        wr(5'h0F, 8'h00);
        wr(5'h0D, 8'h45);
        rd(5'h0D, 8'h45, "R2 secs");
        wr(5'h0D, 8'h00);
        wr(5'h0F, 8'h02);

        // R3 R5: 0.05 s expires on tick 5
        wr(5'h0C, 8'h05);
        rd(5'h0C, 8'h05, "R2 frac");
        ticks(4);
        check(irq, 1'b0, "R3 early 5");
        rd(5'h0E, 8'h00, "R3 no flag before 5");
        ticks(1);
        check(irq, 1'b1, "R5 irq");
        check(wd_rst, 1'b0, "R5 no reset");
        // R7 read returns and clears
        rd(5'h0E, 8'h03, "R7 status");
        check(irq, 1'b0, "R7 irq cleared");
        rd(5'h0E, 8'h00, "R7 status cleared");

        // R10 stays stopped after expiry
        ticks(20);
        check(irq, 1'b0, "R10 no re-expiry");
        rd(5'h0E, 8'h00, "R10 status");

        // R3 decade borrow: 0.10 s
        wr(5'h0C, 8'h10);
        ticks(9);
        check(irq, 1'b0, "R3 early 10");
        ticks(1);
        check(irq, 1'b1, "R3 at 10");
        rd(5'h0E, 8'h03, "R3 status 10");

        // R3 borrow into seconds: 1.00 s
        wr(5'h0C, 8'h00);
        wr(5'h0D, 8'h01);
        ticks(99);
        check(irq, 1'b0, "R3 early 100");
        ticks(1);
        check(irq, 1'b1, "R3 at 100");
        rd(5'h0E, 8'h03, "R3 status 100");
        wr(5'h0D, 8'h00);

        // R4 disabled ticks are ignored
        wr(5'h0F, 8'h00);
        wr(5'h0C, 8'h03);
        ticks(10);
        check(irq, 1'b0, "R4 disabled");
        wr(5'h0F, 8'h02);
        ticks(2);
        check(irq, 1'b0, "R4 count held");
        ticks(1);
        check(irq, 1'b1, "R4 resumes");
        rd(5'h0E, 8'h03, "R4 status");

        // R8 rewrite restarts the count
        wr(5'h0C, 8'h04);
        ticks(3);
        wr(5'h0D, 8'h00);
        ticks(3);
        check(irq, 1'b0, "R8 restarted");
        ticks(1);
        check(irq, 1'b1, "R8 at 4");
        rd(5'h0E, 8'h03, "R8 status");

        // R9 zero never expires
        wr(5'h0C, 8'h00);
        ticks(50);
        check(irq, 1'b0, "R9 zero");
        rd(5'h0E, 8'h00, "R9 status");

        // R6 steering to reset pulse
        wr(5'h0F, 8'h03);
        wr(5'h0C, 8'h02);
        ticks(1);
        check(wd_rst, 1'b0, "R6 early");
        ticks(1);
        check(irq, 1'b0, "R6 no irq");
        n = 0;
        while (wd_rst && n < 40) begin
            n++;
            @(negedge clk);
        end
        total++;
        if (n != 16) begin
            bad++;
            $display("FAIL R6 pulse len act=%0d exp=16", n);
        end
        rd(5'h0E, 8'h02, "R6 status");

        idle(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule